// File: doc/BRIEF.md
# Serial Transceiver with Five-Way Parity

This block is an asynchronous serial transmitter and receiver that share one parity setting. A 3-bit mode input chooses between even parity, odd parity, a parity bit held at 0, a parity bit held at 1, or no parity bit. The transmitter accepts a byte over a valid/ready handshake and sends it as a start bit, eight data bits least significant first, the parity bit when one is enabled, and a stop bit. Every bit lasts `OVS*DIV` clocks, where `OVS` is the oversampling ratio and `DIV` is the clock divider for one oversampling tick.

The receiver watches its input at the oversampling rate. It treats a low level as a candidate start bit and confirms it half a bit later. It then samples each later bit near its centre. At the stop bit it presents the byte and compares the received parity bit with the bit the current mode predicts. A mismatch sets a sticky error flag, and only a clear pulse resets it.

Back-pressure: the transmit side moves a byte only on a clock where `tx_valid` and `tx_ready` are both high. While a frame is on the line, `tx_ready` stays low. A source may hold `tx_valid` high as long as it wants, and its data is taken on the cycle the handshake completes. The receive side has no ready signal. A received byte is presented for exactly one cycle, and the consumer must take it in that cycle.

Top module: `uart_parity_top`

## Requirements
- R1: The idle line is high. A frame is a low start bit, eight data bits least significant first, an optional parity bit and a high stop bit. Each bit is `OVS*DIV` clocks long, and the start bit appears on the cycle after the handshake.
- R2: `tx_ready` is high only while the transmitter is idle. `tx_data` and `par_mode` are captured when the handshake completes, so a later change of `par_mode` does not alter the frame in flight.
- R3: Mode 3'd1 (even) gives a parity bit equal to the XOR of the eight data bits. For 0x41 the bit is 0.
- R4: Mode 3'd2 (odd) gives the inverse of the even bit. For 0x41 the bit is 1.
- R5: Mode 3'd3 (space) always sends 0, and mode 3'd4 (mark) always sends 1, whatever the data.
- R6: Mode 3'd0 and codes 3'd5 to 3'd7 send no parity bit, so the stop bit follows the last data bit. The receiver never raises the error flag for a frame received in these modes.
- R7: For each complete received frame, `rx_valid` is high for exactly one cycle, during the stop bit, with `rx_data` holding the byte. A frame that is never started produces no pulse.
- R8: In modes 3'd1 to 3'd4, a received parity bit that differs from the expected bit sets `par_err` in the same cycle as `rx_valid`.
- R9: `par_err` stays set until a cycle with `par_clr` high, after which it reads 0.
- R10: If `par_clr` is high in the cycle where a new parity error is detected, `par_err` ends set.
- R11: A low pulse on `rxd` shorter than a third of a bit is rejected and produces no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_mode | input | 3 | Parity mode: 0 none, 1 even, 2 odd, 3 space, 4 mark, 5-7 none |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter idle and able to take a byte |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_valid | output | 1 | One-cycle pulse, received byte present |
| rx_data | output | 8 | Received byte |
| par_clr | input | 1 | Clear request for the parity error flag |
| par_err | output | 1 | Sticky parity error flag |

## Verification
The hardest case to reach is the one where a clear request and a new parity error arrive on the same clock. The receiver's tick phase cannot be seen from outside, so the bench cannot know the exact cycle of the stop-bit decision in advance. Instead, the bench first leaves the flag set, then sends a frame with a corrupted parity bit. It raises `par_clr` at the start of that frame's stop bit and holds it until it sees `rx_valid`. This forces the clear to cover the decision cycle: the flag first drops, and the error must then set it again, where it stays. A rejected short glitch on the input is driven the same way, without knowing the tick phase. The glitch is kept well under half a bit, so the mid-bit confirmation must always reject it.

// File: rtl/uart_par_pkg.sv
package uart_par_pkg;

  localparam logic [2:0] PM_NONE  = 3'd0;
  localparam logic [2:0] PM_EVEN  = 3'd1;
  localparam logic [2:0] PM_ODD   = 3'd2;
  localparam logic [2:0] PM_SPACE = 3'd3;
  localparam logic [2:0] PM_MARK  = 3'd4;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_START,
    FS_DATA,
    FS_PAR,
    FS_STOP
  } frame_st_e;

  function automatic logic mode_has_parity(input logic [2:0] m);
    return (m == PM_EVEN) || (m == PM_ODD) || (m == PM_SPACE) || (m == PM_MARK);
  endfunction

  // ones_odd: XOR reduction of the data bits
  function automatic logic mode_parity_bit(input logic [2:0] m, input logic ones_odd);
    logic b;
    case (m)
      PM_EVEN: b = ones_odd;
      PM_ODD:  b = ~ones_odd;
      PM_MARK: b = 1'b1;
      default: b = 1'b0;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] C_LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart)          cnt_q <= '0;
    else if (cnt_q == C_LAST)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == C_LAST);
endmodule

// File: rtl/uart_par_tx.sv
module uart_par_tx
  import uart_par_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        par_mode,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              txd
);
  localparam int TCW = $clog2(OVS);
  localparam int IW  = $clog2(DATA_W);
  localparam logic [TCW-1:0] T_LAST = TCW'(OVS - 1);
  localparam logic [IW-1:0]  I_LAST = IW'(DATA_W - 1);

  frame_st_e         st_q;
  logic [TCW-1:0]    tcnt_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              pbit_q;
  logic              has_p_q;
  logic              tick;
  logic              accept;

  assign tx_ready = (st_q == FS_IDLE);
  assign accept   = tx_valid && tx_ready;

  uart_tick_gen #(.DIV(DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .tick    (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FS_IDLE;
      txd     <= 1'b1;
      tcnt_q  <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      has_p_q <= 1'b0;
    end else if (accept) begin
      st_q    <= FS_START;
      txd     <= 1'b0;
      tcnt_q  <= '0;
      sh_q    <= tx_data;
      pbit_q  <= mode_parity_bit(par_mode, ^tx_data);
      has_p_q <= mode_has_parity(par_mode);
    end else if (st_q != FS_IDLE && tick) begin
      if (tcnt_q != T_LAST) begin
        tcnt_q <= tcnt_q + 1'b1;
      end else begin
        tcnt_q <= '0;
        case (st_q)
          FS_START: begin
            st_q  <= FS_DATA;
            idx_q <= '0;
            txd   <= sh_q[0];
            sh_q  <= sh_q >> 1;
          end
          FS_DATA: begin
            if (idx_q == I_LAST) begin
              st_q <= has_p_q ? FS_PAR : FS_STOP;
              txd  <= has_p_q ? pbit_q : 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
              txd   <= sh_q[0];
              sh_q  <= sh_q >> 1;
            end
          end
          FS_PAR: begin
            st_q <= FS_STOP;
            txd  <= 1'b1;
          end
          default: begin
            st_q <= FS_IDLE;
            txd  <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_par_rx.sv
module uart_par_rx
  import uart_par_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        par_mode,
  input  logic              rxd,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              err_evt,
  output logic [2:0]        frame_mode
);
  localparam int TCW = $clog2(OVS);
  localparam int IW  = $clog2(DATA_W);
  localparam logic [TCW-1:0] T_LAST = TCW'(OVS - 1);
  localparam logic [TCW-1:0] T_HALF = TCW'(OVS / 2 - 1);
  localparam logic [IW-1:0]  I_LAST = IW'(DATA_W - 1);

  frame_st_e         st_q;
  logic [TCW-1:0]    tcnt_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              psamp_q;
  logic [2:0]        mode_q;
  logic              s1_q, s2_q;
  logic              tick;
  logic              bit_mid;

  uart_tick_gen #(.DIV(DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (1'b0),
    .tick    (tick)
  );

  assign bit_mid    = tick && (tcnt_q == T_LAST);
  assign frame_mode = mode_q;
  assign err_evt    = (st_q == FS_STOP) && bit_mid && mode_has_parity(mode_q) &&
                      (psamp_q != mode_parity_bit(mode_q, ^sh_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= FS_IDLE;
      tcnt_q   <= '0;
      idx_q    <= '0;
      sh_q     <= '0;
      psamp_q  <= 1'b0;
      mode_q   <= PM_NONE;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (st_q)
        FS_IDLE: if (tick && !s2_q) begin
          st_q   <= FS_START;
          tcnt_q <= '0;
          mode_q <= par_mode;
        end
        FS_START: if (tick) begin
          if (tcnt_q == T_HALF) begin
            tcnt_q <= '0;
            idx_q  <= '0;
            st_q   <= s2_q ? FS_IDLE : FS_DATA;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: if (tick) begin
          if (tcnt_q != T_LAST) begin
            tcnt_q <= tcnt_q + 1'b1;
          end else begin
            tcnt_q <= '0;
            if (st_q == FS_DATA) begin
              sh_q <= {s2_q, sh_q[DATA_W-1:1]};
              if (idx_q == I_LAST) st_q <= mode_has_parity(mode_q) ? FS_PAR : FS_STOP;
              else                 idx_q <= idx_q + 1'b1;
            end else if (st_q == FS_PAR) begin
              psamp_q <= s2_q;
              st_q    <= FS_STOP;
            end else begin
              st_q     <= FS_IDLE;
              rx_valid <= 1'b1;
              rx_data  <= sh_q;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_parity_top.sv
module uart_parity_top #(
  parameter int OVS = 16,
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] par_mode,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       txd,
  input  logic       rxd,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  input  logic       par_clr,
  output logic       par_err
);
  logic       err_evt;
  logic [2:0] rx_mode;

  uart_par_tx #(.DATA_W(8), .OVS(OVS), .DIV(DIV)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_mode (par_mode),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .txd      (txd)
  );

  uart_par_rx #(.DATA_W(8), .OVS(OVS), .DIV(DIV)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_mode   (par_mode),
    .rxd        (rxd),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .err_evt    (err_evt),
    .frame_mode (rx_mode)
  );

  // a fresh error outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       par_err <= 1'b0;
    else if (err_evt) par_err <= 1'b1;
    else if (par_clr) par_err <= 1'b0;
  end
endmodule

// File: rtl/uart_parity_chk.sv
module uart_parity_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       rx_valid,
  input logic       par_clr,
  input logic       par_err,
  input logic [2:0] rx_mode
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd); // R1

  AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready && !txd); // R2

  AST_RX_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7

  AST_ERR_NEEDS_PARITY_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> rx_valid && (rx_mode inside {3'd1, 3'd2, 3'd3, 3'd4})); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    par_err && !par_clr |=> par_err); // R9

  AST_CLR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(par_clr) && !rx_valid |-> !par_err); // R9
endmodule

bind uart_parity_top uart_parity_chk u_chk (.*);

// File: tb/uart_parity_top_bench.sv
module uart_parity_top_bench;
  localparam int OVS = 16;
  localparam int DIV = 4;
  localparam int BIT = OVS * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] par_mode = 3'd0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, txd, rx_valid, par_err;
  logic [7:0] rx_data;
  logic       rxd = 1'b1;
  logic       par_clr = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  uart_parity_top #(.OVS(OVS), .DIV(DIV)) u_uart_parity_top (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit par_of(input logic [2:0] m, input logic [7:0] d);
    int ones = $countones(d);
    case (m)
      3'd1: return bit'(ones % 2);
      3'd2: return bit'(!(ones % 2));
      3'd4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit has_par(input logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd4);
  endfunction

  function automatic string par_tag(input logic [2:0] m);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // ---------------- transmit reference model ----------------
  bit         fb[$];
  int         tn = 0;
  bit         tbusy = 0;
  bit         acc_pend = 0;
  logic [7:0] acc_d;
  logic [2:0] acc_m;
  logic [2:0] cur_m;

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_txd;
      string tg;
      if (acc_pend) begin
        fb.delete();
        fb.push_back(1'b0);
        for (int i = 0; i < 8; i++) fb.push_back(acc_d[i]);
        if (has_par(acc_m)) fb.push_back(par_of(acc_m, acc_d));
        fb.push_back(1'b1);
        cur_m = acc_m; tn = 0; tbusy = 1; acc_pend = 0;
      end else if (tbusy) begin
        tn++;
        if (tn >= fb.size() * BIT) tbusy = 0;
      end
      exp_txd = tbusy ? fb[tn / BIT] : 1'b1;
      tg = (tbusy && has_par(cur_m) && (tn / BIT) == 9) ? par_tag(cur_m) : "R1";
      if (tbusy && !has_par(cur_m) && (tn / BIT) == 9) tg = "R6";
      chk(txd === exp_txd, tg, "txd", int'(txd), int'(exp_txd));
      chk(tx_ready === !tbusy, "R2", "tx_ready", int'(tx_ready), int'(!tbusy));
      if (tx_valid && !tbusy) begin
        acc_pend = 1; acc_d = tx_data; acc_m = par_mode;
      end
    end
  end

  // ---------------- receive reference model ----------------
  bit         rx_expect = 0;
  bit         rx_exp_err = 0;
  logic [7:0] rx_exp_byte;
  int         rx_seen = 0;
  bit         flag_exp = 0;
  bit         clr_seen = 0;

  always @(posedge clk) clr_seen = par_clr;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        rx_seen++;
        chk(rx_expect, "R7", "unexpected rx_valid", 1, 0);
        chk(rx_data === rx_exp_byte, "R7", "rx_data", int'(rx_data), int'(rx_exp_byte));
        if (rx_exp_err) flag_exp = 1;
        else if (clr_seen) flag_exp = 0;
      end else if (clr_seen) begin
        flag_exp = 0;
      end
      chk(par_err === flag_exp, rx_exp_err ? "R8" : "R9", "par_err", int'(par_err), int'(flag_exp));
    end
  end

  task automatic tx_send(input logic [7:0] d, input logic [2:0] m);
    while (!tx_ready) begin @(posedge clk); #1; end
    tx_data = d; par_mode = m; tx_valid = 1'b1;
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic tx_drain;
    @(posedge clk); #1;
    while (!tx_ready) begin @(posedge clk); #1; end
    repeat (4) @(posedge clk); #1;
  endtask

  // drives one frame on rxd; flip corrupts the parity bit; collide holds par_clr over the decision
  task automatic rx_send(input logic [7:0] d, input logic [2:0] m, input bit flip, input bit collide,
                         input string req);
    bit bits[$];
    bits.push_back(1'b0);
    for (int i = 0; i < 8; i++) bits.push_back(d[i]);
    if (has_par(m)) bits.push_back(par_of(m, d) ^ flip);
    par_mode = m;
    rx_exp_byte = d;
    rx_exp_err = has_par(m) && flip;
    rx_seen = 0;
    rx_expect = 1;
    foreach (bits[i]) begin
      rxd = bits[i];
      repeat (BIT) @(posedge clk);
      #1;
    end
    rxd = 1'b1;
    if (collide) begin
      par_clr = 1'b1;
      for (int g = 0; g < 2 * BIT; g++) begin
        @(negedge clk);
        if (rx_valid) break;
      end
      #1 par_clr = 1'b0;
    end
    repeat (2 * BIT) @(posedge clk);
    #1;
    rx_expect = 0;
    chk(rx_seen == 1, req, "rx_valid pulses per frame", rx_seen, 1);
    rx_exp_err = 0;
  endtask

  task automatic clear_flag;
    par_clr = 1'b1;
    @(posedge clk); #1;
    par_clr = 1'b0;
    @(negedge clk);
    chk(par_err === 1'b0, "R9", "par_err after clear", int'(par_err), 0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R1", "reset txd", int'(txd), 1);
    chk(tx_ready === 1'b1, "R2", "reset tx_ready", int'(tx_ready), 1);
    chk(rx_valid === 1'b0, "R7", "reset rx_valid", int'(rx_valid), 0);
    chk(par_err === 1'b0, "R9", "reset par_err", int'(par_err), 0);
    @(posedge clk); #1;

    // transmit: 0x41 under all modes (R3 R4 R5 R6), then other patterns
    tx_send(8'h41, 3'd1); tx_drain();
    tx_send(8'h41, 3'd2); tx_drain();
    tx_send(8'h41, 3'd4); tx_drain();
    tx_send(8'h41, 3'd3); tx_drain();
    tx_send(8'h41, 3'd0); tx_drain();
    tx_send(8'hFF, 3'd1); tx_drain();
    tx_send(8'h00, 3'd2); tx_drain();
    tx_send(8'hA5, 3'd6); tx_drain();
    // back-to-back with mode changed mid-frame (R2)
    tx_send(8'h3C, 3'd2);
    repeat (5) @(posedge clk); #1;
    par_mode = 3'd3;
    tx_send(8'hC3, 3'd4);
    tx_drain();

    // receive: clean frames in each mode (R7)
    rx_send(8'h41, 3'd1, 0, 0, "R7");
    rx_send(8'h41, 3'd2, 0, 0, "R7");
    rx_send(8'h96, 3'd3, 0, 0, "R7");
    rx_send(8'h69, 3'd4, 0, 0, "R7");
    rx_send(8'h5A, 3'd0, 0, 0, "R6");
    // corrupted parity sets the flag (R8), which stays over a clean frame (R9)
    rx_send(8'h41, 3'd1, 1, 0, "R8");
    chk(par_err === 1'b1, "R8", "flag after even error", int'(par_err), 1);
    rx_send(8'h12, 3'd2, 0, 0, "R9");
    chk(par_err === 1'b1, "R9", "flag sticky", int'(par_err), 1);
    clear_flag();
    rx_send(8'h41, 3'd4, 1, 0, "R5");
    chk(par_err === 1'b1, "R5", "mark error", int'(par_err), 1);
    clear_flag();
    rx_send(8'h41, 3'd3, 1, 0, "R5");
    chk(par_err === 1'b1, "R5", "space error", int'(par_err), 1);
    clear_flag();
    rx_send(8'hF0, 3'd2, 1, 0, "R4");
    chk(par_err === 1'b1, "R4", "odd error", int'(par_err), 1);
    clear_flag();
    // no-parity mode: nothing flagged (R6)
    rx_send(8'h7E, 3'd7, 0, 0, "R6");
    chk(par_err === 1'b0, "R6", "no flag without parity", int'(par_err), 0);
    // clear and fresh error together: error wins (R10)
    rx_send(8'h41, 3'd1, 1, 0, "R8");
    rx_send(8'h41, 3'd2, 1, 1, "R10");
    chk(par_err === 1'b1, "R10", "flag after collision", int'(par_err), 1);
    clear_flag();
    // short glitch rejected (R11)
    rx_seen = 0;
    rxd = 1'b0;
    repeat (3 * DIV) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (20 * BIT) @(posedge clk);
    #1;
    chk(rx_seen == 0, "R11", "pulses after glitch", rx_seen, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule